// File: doc/BRIEF.md
# Triggered Delay-and-Width Pulse Timer

This block turns an edge on an external trigger pin into one output pulse placed in time under software control. Once a trigger rising edge is seen, the block counts a programmed number of time-base events, raises its output, holds it for a second programmed number of events, then lowers it and waits for the next trigger. The counts are measured either on a one-cycle microsecond strobe from inside the chip or on the rising edges of an external clock pin.

The block can signal one chosen moment to an interrupt controller. It can mark the accepted trigger, the rising edge of the output or its falling edge, or it can stay silent. Software sets the delay, the width and a small configuration word through a plain write port with an address.

Top module: `pulse_delay_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pulse_out` and `irq_out` are 0. All three registers reset to 0.
- R2: A write with `wr_en` high stores `wr_data` at the next clock edge. Address 0 holds the delay count and address 1 holds the width count. Address 2 holds the configuration: bits [1:0] are the interrupt select and bit 2 is the time-base select. A write to address 3 changes nothing.
- R3: `trig_in` passes through a two-flop synchronizer and only its rising edge is used. The trigger event falls in the cycle before the third clock edge after the input rose. A trigger input held high starts only one sequence.
- R4: With delay D, `pulse_out` rises at the clock edge of the (D+1)-th time-base event after the trigger event. A delay of 0 rises on the first event.
- R5: With width W, `pulse_out` falls at the clock edge of the W-th time-base event after it rose. A width of 0 behaves as a width of 1.
- R6: Configuration bit 2 = 0 uses `us_tick` directly: each high cycle is one event. Bit 2 = 1 uses each rising edge of `ext_clk_in`, seen after a two-flop synchronizer.
- R7: A trigger edge that arrives while a sequence is in progress is ignored. It does not restart or lengthen the pulse.
- R8: Interrupt select 00 marks an accepted trigger, 01 marks the output rising edge and 10 marks the output falling edge. `irq_out` is a one-cycle pulse that is high in the cycle that follows the event cycle.
- R9: Interrupt select 11 keeps `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| trig_in | input | 1 | Asynchronous trigger input |
| ext_clk_in | input | 1 | Asynchronous external time base |
| us_tick | input | 1 | Internal one-cycle microsecond strobe |
| pulse_out | output | 1 | Generated pulse |
| irq_out | output | 1 | One-cycle interrupt request |

## Verification
The bench targets three corner cases. The first is a delay of zero, where a design that counts one event too many places the rising edge one period late. The second is a width of zero, where a design that does not treat zero as one either wraps to a 256-event pulse or never raises the output at all. The third is a second trigger edge during the delay phase, which a faulty design would use to reload the counter and push the pulse out.

The bench also switches the time base to the external clock, where a missing synchronizer or a level-based event would shift every edge. It runs the maximum delay with a tick on every cycle. It holds the trigger high so that a level-sensitive start would fire repeatedly. It writes to the unused address, where a loose decode would overwrite a live register. It also steps through every interrupt select code, so that a swapped decode shows up as an interrupt on the wrong edge or on the silent code.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_WAIT = 2'b01,
      PH_HIGH = 2'b10
   } phase_e;

   localparam logic [1:0] IRQ_ON_TRIG = 2'b00;
   localparam logic [1:0] IRQ_ON_RISE = 2'b01;
   localparam logic [1:0] IRQ_ON_FALL = 2'b10;
   localparam logic [1:0] IRQ_NONE    = 2'b11;
endpackage

// File: rtl/pdg_edge_sync.sv
module pdg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "pdg_edge_sync: STAGES must be at least 2");
   end

   // chain[LAST] is the synchronized level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_i};
   end

   assign rise_o = chain[LAST] & ~chain[STAGES];

   p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/pdg_cfg_regs.sv
module pdg_cfg_regs #(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  delay_o,
   output logic [CNT_W-1:0]  width_o,
   output logic [1:0]        irq_sel_o,
   output logic              tb_ext_o
);
   localparam logic [ADDR_W-1:0] A_DELAY = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_WIDTH = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(2);

   if (CNT_W < 3) begin : g_bad_width
      initial $fatal(1, "pdg_cfg_regs: CNT_W must hold the 3 configuration bits");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      initial $fatal(1, "pdg_cfg_regs: ADDR_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delay_o   <= '0;
         width_o   <= '0;
         irq_sel_o <= 2'b00;
         tb_ext_o  <= 1'b0;
      end else if (wr_en) begin
         unique case (wr_addr)
            A_DELAY: delay_o <= wr_data;
            A_WIDTH: width_o <= wr_data;
            A_CFG: begin
               irq_sel_o <= wr_data[1:0];
               tb_ext_o  <= wr_data[2];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pdg_sequencer.sv
module pdg_sequencer
   import pdg_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_ev,
   input  logic             tb_ev,
   input  logic [CNT_W-1:0] delay_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             pulse_o,
   output logic             acc_o,
   output logic             rise_o,
   output logic             fall_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_e           phase;
   logic [CNT_W-1:0] cnt;

   // event strobes for the interrupt selector, valid in the cycle before the edge
   assign acc_o  = (phase == PH_IDLE) && trig_ev;
   assign rise_o = (phase == PH_WAIT) && tb_ev && (cnt == '0);
   assign fall_o = (phase == PH_HIGH) && tb_ev && (cnt <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (trig_ev) begin
               phase <= PH_WAIT;
               cnt   <= delay_i;
            end
            PH_WAIT: if (tb_ev) begin
               if (cnt == '0) begin
                  phase <= PH_HIGH;
                  cnt   <= width_i;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            PH_HIGH: if (tb_ev) begin
               if (cnt <= ONE) phase <= PH_IDLE;
               else            cnt   <= cnt - ONE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign pulse_o = (phase == PH_HIGH);

   p_busy_trig_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && trig_ev && !tb_ev) |=> (phase == PH_WAIT && cnt == $past(cnt)));
   p_rise_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |-> $past(tb_ev));
   p_fall_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_o) |-> $past(tb_ev));
endmodule

// File: rtl/pulse_delay_gen.sv
module pulse_delay_gen
   import pdg_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              trig_in,
   input  logic              ext_clk_in,
   input  logic              us_tick,
   output logic              pulse_out,
   output logic              irq_out
);
   logic [CNT_W-1:0] delay_r, width_r;
   logic [1:0]       irq_sel;
   logic             tb_ext;
   logic             trig_ev, ext_ev, tb_ev;
   logic             ev_acc, ev_rise, ev_fall;
   logic             irq_q;

   pdg_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .delay_o(delay_r), .width_o(width_r), .irq_sel_o(irq_sel), .tb_ext_o(tb_ext)
   );

   pdg_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .async_i(trig_in), .rise_o(trig_ev)
   );

   pdg_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ext_clk_in), .rise_o(ext_ev)
   );

   assign tb_ev = tb_ext ? ext_ev : us_tick;

   pdg_sequencer #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .trig_ev(trig_ev), .tb_ev(tb_ev),
      .delay_i(delay_r), .width_i(width_r), .pulse_o(pulse_out),
      .acc_o(ev_acc), .rise_o(ev_rise), .fall_o(ev_fall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         unique case (irq_sel)
            IRQ_ON_TRIG: irq_q <= ev_acc;
            IRQ_ON_RISE: irq_q <= ev_rise;
            IRQ_ON_FALL: irq_q <= ev_fall;
            default:     irq_q <= 1'b0;
         endcase
      end
   end

   assign irq_out = irq_q;

   p_irq_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_sel) == IRQ_NONE) |-> !irq_out);
   p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && $past(irq_sel) == IRQ_ON_RISE) |-> pulse_out);
   p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && $past(irq_sel) == IRQ_ON_FALL) |-> (!pulse_out && $past(pulse_out)));
   p_irq_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && $past(irq_sel) == IRQ_ON_TRIG) |-> !pulse_out);
endmodule

// File: tb/pulse_delay_gen_bench.sv
module pulse_delay_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       trig_in = 1'b0;
   logic       ext_clk_in = 1'b0;
   logic       us_tick = 1'b0;
   logic       pulse_out, irq_out;

   int checks = 0, fails = 0, cycles = 0;
   string cur_req = "R1";
   int tick_period = 5, tick_cnt = 0;
   int ext_half = 6, ext_cnt = 0;
   int irq_seen = 0, rise_seen = 0;
   bit prev_pulse = 1'b0;

   // behavioural reference state
   int m_delay = 0, m_width = 0, m_sel = 0, m_ext = 0, ph = 0, rem = 0;
   bit m_pulse = 1'b0, m_irq = 1'b0;
   bit tq[$] = '{1'b0, 1'b0, 1'b0};
   bit eq[$] = '{1'b0, 1'b0, 1'b0};

   pulse_delay_gen u_pulse_delay_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .trig_in(trig_in), .ext_clk_in(ext_clk_in), .us_tick(us_tick),
      .pulse_out(pulse_out), .irq_out(irq_out)
   );

   always #2 clk = ~clk;

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog run did not finish actual=%0d expected=0", cycles);
         finish_run();
      end
   end

   // time-base stimulus
   always @(negedge clk) begin
      if (tick_cnt >= tick_period - 1) begin tick_cnt <= 0; us_tick <= 1'b1; end
      else begin tick_cnt <= tick_cnt + 1; us_tick <= 1'b0; end
      if (ext_cnt >= ext_half - 1) begin ext_cnt <= 0; ext_clk_in <= ~ext_clk_in; end
      else ext_cnt <= ext_cnt + 1;
   end

   // reference model: acts on the values present at each rising edge
   always @(posedge clk) begin : model
      bit t_ev, e_ev, tb, acc, rs, fl;
      if (!rst_n) begin
         m_delay = 0; m_width = 0; m_sel = 0; m_ext = 0; ph = 0; rem = 0;
         m_pulse = 1'b0; m_irq = 1'b0;
         tq = '{1'b0, 1'b0, 1'b0};
         eq = '{1'b0, 1'b0, 1'b0};
      end else begin
         t_ev = tq[1] && !tq[2];
         e_ev = eq[1] && !eq[2];
         tq.push_front(trig_in);     void'(tq.pop_back());
         eq.push_front(ext_clk_in);  void'(eq.pop_back());
         tb = (m_ext != 0) ? e_ev : us_tick;
         acc = 1'b0; rs = 1'b0; fl = 1'b0;
         if (ph == 0) begin
            if (t_ev) begin ph = 1; rem = m_delay; acc = 1'b1; end
         end else if (ph == 1) begin
            if (tb) begin
               if (rem == 0) begin ph = 2; rem = m_width; rs = 1'b1; end
               else rem--;
            end
         end else begin
            if (tb) begin
               if (rem <= 1) begin ph = 0; fl = 1'b1; end
               else rem--;
            end
         end
         m_irq = (m_sel == 0 && acc) || (m_sel == 1 && rs) || (m_sel == 2 && fl);
         m_pulse = (ph == 2);
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_delay = int'(wr_data);
               2'd1: m_width = int'(wr_data);
               2'd2: begin m_sel = int'(wr_data[1:0]); m_ext = int'(wr_data[2]); end
               default: ;
            endcase
         end
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, int'(pulse_out), int'(m_pulse), "pulse_out vs model");
         check(cur_req, int'(irq_out), int'(m_irq), "irq_out vs model");
         if (irq_out) irq_seen++;
         if (pulse_out && !prev_pulse) rise_seen++;
         prev_pulse = pulse_out;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_trig(input int hold);
      @(negedge clk);
      trig_in = 1'b1;
      repeat (hold) @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (8) @(negedge clk);
      while (ph != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic clear_counts();
      irq_seen = 0; rise_seen = 0;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", int'(pulse_out), 0, "pulse_out in reset");
      check("R1", int'(irq_out), 0, "irq_out in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(pulse_out), 0, "pulse_out after reset");
      check("R1", int'(irq_out), 0, "irq_out after reset");

      // R4/R5/R8 trigger-interrupt on tick base, delay 3 width 2
      cur_req = "R4"; tick_period = 5; clear_counts();
      wr(2'd0, 8'd3); wr(2'd1, 8'd2); wr(2'd2, 8'h00);
      pulse_trig(3);
      wait_idle();
      check("R8", irq_seen, 1, "trigger irq count");
      check("R4", rise_seen, 1, "pulse count");

      // R4/R5 delay 0 and width 0, rise irq
      cur_req = "R5"; tick_period = 7; clear_counts();
      wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'h01);
      pulse_trig(1);
      wait_idle();
      check("R8", irq_seen, 1, "rise irq count");
      check("R5", rise_seen, 1, "zero width pulse count");

      // R6 external clock time base, fall irq
      cur_req = "R6"; ext_half = 6; clear_counts();
      wr(2'd0, 8'd2); wr(2'd1, 8'd3); wr(2'd2, 8'h06);
      pulse_trig(2);
      wait_idle();
      check("R6", irq_seen, 1, "fall irq count on external base");
      check("R6", rise_seen, 1, "pulse count on external base");

      // R7/R9 retriggers during sequence, silent irq
      cur_req = "R7"; tick_period = 4; clear_counts();
      wr(2'd0, 8'd10); wr(2'd1, 8'd5); wr(2'd2, 8'h03);
      pulse_trig(2);
      repeat (12) @(negedge clk);
      pulse_trig(2);
      repeat (30) @(negedge clk);
      pulse_trig(2);
      wait_idle();
      check("R7", rise_seen, 1, "retrigger pulse count");
      check("R9", irq_seen, 0, "silent irq count");

      // R2 write to unused address, then maximum delay with tick every cycle
      cur_req = "R2"; tick_period = 1; clear_counts();
      wr(2'd0, 8'd255); wr(2'd1, 8'd1); wr(2'd2, 8'h01);
      wr(2'd3, 8'h02);
      pulse_trig(1);
      wait_idle();
      check("R2", irq_seen, 1, "rise irq after unused-address write");
      check("R4", rise_seen, 1, "max delay pulse count");

      // R3 trigger held high starts one sequence only
      cur_req = "R3"; tick_period = 3; clear_counts();
      wr(2'd0, 8'd1); wr(2'd1, 8'd2); wr(2'd2, 8'h00);
      @(negedge clk);
      trig_in = 1'b1;
      repeat (80) @(negedge clk);
      check("R3", rise_seen, 1, "held trigger pulse count");
      check("R3", irq_seen, 1, "held trigger irq count");
      trig_in = 1'b0;
      wait_idle();

      finish_run();
   end
endmodule